// File: doc/BRIEF.md
# Configuration DMA Engine

This block gives firmware a bulk path into a table of configuration items. Software places a 16-byte descriptor in system memory, then writes the descriptor's 64-bit address into a small register window. The engine then runs on its own. It fetches the descriptor, optionally switches the current item, and moves bytes in one of three ways: from the item into memory, from memory into a writable item, or past item bytes without touching memory. At the end it writes a completion word back over the descriptor's control field.

The current item key and the byte offset within that item are shared with a simple host selector port. A byte transfer continues from wherever the last access left the offset. A read that runs off the end of an item, or that targets an absent item, fills the rest of the destination with zeros instead of failing. The item table itself lives outside the block. The engine only sees the presence, length, writability and byte at the current key and offset. All memory traffic is byte-serial on a request/response master port.

Top module: `cfgdma_top`

## Requirements
- R1: After reset the engine is idle (busy low, no memory request), the current key is 0 and the current offset is 0.
- R2: A window read of `win_size` bytes at `win_off` returns bytes off..off+size-1 of the constant 0x51454D5520434647, where byte 0 is the most significant byte (0x51). The value is right-aligned in `win_rdata`. A combination with off+size above 8 returns 0.
- R3: A 4-byte window write at offset 4 (low address half) or an 8-byte write at offset 0 starts a transfer. A 4-byte write at offset 0 only loads the high half and starts nothing.
- R4: The descriptor is big-endian. Bytes 0-3 hold the control word, bytes 4-7 the length and bytes 8-15 the target address. The control bits are: bit 0 error, bit 1 read, bit 2 skip, bit 3 select, bit 4 write. Bits 31:16 carry a key.
- R5: With the select bit set, the key is made current and the offset is reset to 0 before any data moves. A control word with none of read/write/skip moves no data and reports success. A control word arriving with the error bit set moves no data and reports an error.
- R6: A read copies item bytes from the current offset to ascending target addresses. Bytes past the item's end, or from an absent item, are written as zeros. The offset advances only over real item bytes.
- R7: A write copies memory bytes into the item at the current offset if the item is writable. Reaching a read-only item, an absent item or the item's end sets the error flag, and the transfer stops there.
- R8: A skip advances the offset over item bytes without any data memory access.
- R9: When several operation bits are set, read wins over write, and write wins over skip.
- R10: A failed memory response during the descriptor fetch or the data phase sets the error flag and ends the data phase. A fetch failure leaves the current key unchanged.
- R11: On completion the engine writes the 4-byte big-endian status 0x00000001 (error) or 0x00000000 (success) at the descriptor address. `busy` is high from the trigger until that write completes, and there are no memory requests while idle.
- R12: Window writes are ignored while busy. A host select is ignored while busy. A host select when idle, including the trigger cycle, is applied before the transfer runs.
- R13: Each memory access moves one byte. Request, direction, address and write data stay stable until the response. A transfer of n data bytes makes 16 + n + 4 accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_we | input | 1 | Window write strobe |
| win_off | input | 3 | Window byte offset |
| win_size | input | 4 | Window access size in bytes (1 to 8) |
| win_wdata | input | 64 | Window write data, right-aligned |
| win_rdata | output | 64 | Window read data (signature slice) |
| busy | output | 1 | Transfer in progress |
| host_sel | input | 1 | Host selector strobe |
| host_key | input | 16 | Key chosen by the host |
| cur_key | output | 16 | Current item key (table index) |
| cur_off | output | OFF_W | Current byte offset in the item |
| tbl_present | input | 1 | Item at cur_key exists |
| tbl_len | input | OFF_W | Item length in bytes |
| tbl_writable | input | 1 | Item accepts writes |
| tbl_rbyte | input | 8 | Item byte at cur_off |
| tbl_we | output | 1 | Write one byte at cur_off |
| tbl_wbyte | output | 8 | Byte to write into the item |
| mem_req | output | 1 | Memory request, held until response |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rsp | input | 1 | Response strobe |
| mem_err | input | 1 | Response reports a fault |
| mem_rdata | input | 8 | Read byte, valid with mem_rsp |

## Verification
Two events can land in the same clock edge: the host selector strobe and the window write that starts a transfer. The bench raises both together, with a descriptor that carries no select bit. The copied bytes must then come from the host's freshly chosen item, starting at offset 0. A second host select and a second trigger are raised while the first transfer is running. The final key and offset must still be those of the first transfer, and the second target region must stay untouched.

// File: rtl/cfgdma_pkg.sv
// Shared constants and types for the configuration DMA engine.
// Assumes the descriptor format is fixed: 32-bit control, 32-bit length, 64-bit target.
package cfgdma_pkg;
    localparam int KEY_W      = 16;
    localparam int DLEN_W     = 32;
    localparam int DESC_BYTES = 16;
    localparam int STAT_BYTES = 4;
    localparam int FLG_W      = 5;

    // control word bit positions (software-visible encoding)
    localparam int CTL_ERR  = 0;
    localparam int CTL_RD   = 1;
    localparam int CTL_SKIP = 2;
    localparam int CTL_SEL  = 3;
    localparam int CTL_WR   = 4;

    localparam logic [63:0] WIN_SIGNATURE = 64'h51454d5520434647;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_DECODE, ST_MOVE, ST_WBACK
    } eng_state_e;

    typedef enum logic [1:0] {
        OP_NONE, OP_RD, OP_WR, OP_SKIP
    } op_e;
endpackage

// File: rtl/cfgdma_regwin.sv
// Register window: holds the descriptor address, raises a start pulse and
// serves the constant signature on reads.
// Assumes accesses are naturally sized (1..8 bytes); all writes are dropped while busy.
module cfgdma_regwin
    import cfgdma_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_we,
    input  logic [2:0]        win_off,
    input  logic [3:0]        win_size,
    input  logic [63:0]       win_wdata,
    output logic [63:0]       win_rdata,
    input  logic              busy,
    output logic [ADDR_W-1:0] desc_addr,
    output logic              go
);
    logic [63:0] addr_q;
    logic [63:0] addr_d;
    logic        wr_hi;
    logic        wr_lo;
    logic        wr_all;
    logic [3:0]  end_b;
    logic [6:0]  sh;
    logic [6:0]  nbits;
    logic [63:0] mask;

    // decode the three accepted write shapes
    always_comb begin
        wr_hi  = win_we && !busy && (win_off == 3'd0) && (win_size == 4'd4);
        wr_lo  = win_we && !busy && (win_off == 3'd4) && (win_size == 4'd4);
        wr_all = win_we && !busy && (win_off == 3'd0) && (win_size == 4'd8);
    end

    // next descriptor address value
    always_comb begin
        addr_d = addr_q;
        if (wr_hi)  addr_d = {win_wdata[31:0], 32'h0};
        if (wr_lo)  addr_d = {addr_q[63:32], win_wdata[31:0]};
        if (wr_all) addr_d = win_wdata;
    end

    // address register
    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign go        = wr_lo || wr_all;
    assign desc_addr = addr_d[ADDR_W-1:0];

    // signature slice, most significant byte at offset 0
    always_comb begin
        end_b     = {1'b0, win_off} + win_size;
        sh        = {(4'd8 - end_b), 3'b000};
        nbits     = {win_size, 3'b000};
        mask      = (nbits == 7'd64) ? '1 : ((64'd1 << nbits) - 64'd1);
        win_rdata = '0;
        if (win_size != 4'd0 && end_b <= 4'd8)
            win_rdata = (WIN_SIGNATURE >> sh) & mask;
    end
endmodule

// File: rtl/cfgdma_cursor.sv
// Current item cursor (key and byte offset) shared between host selector and engine.
// Assumes the engine select and host select never coincide (host is gated while busy).
module cfgdma_cursor
    import cfgdma_pkg::*;
#(
    parameter int OFF_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_sel,
    input  logic [KEY_W-1:0] host_key,
    input  logic             eng_sel,
    input  logic [KEY_W-1:0] eng_key,
    input  logic             adv,
    output logic [KEY_W-1:0] cur_key,
    output logic [OFF_W-1:0] cur_off
);
    // select resets the offset; advance steps it by one byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_key <= '0;
            cur_off <= '0;
        end else if (eng_sel) begin
            cur_key <= eng_key;
            cur_off <= '0;
        end else if (host_sel) begin
            cur_key <= host_key;
            cur_off <= '0;
        end else if (adv) begin
            cur_off <= cur_off + 1'b1;
        end
    end
endmodule

// File: rtl/cfgdma_engine.sv
// Transfer engine: fetches the descriptor byte by byte, applies select, runs
// the read/write/skip data phase and writes the status word back.
// Assumes one outstanding memory access; the table answers combinationally at cur_off.
module cfgdma_engine
    import cfgdma_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int OFF_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] base_in,
    output logic              busy,
    output logic              sel_pulse,
    output logic [KEY_W-1:0]  sel_key,
    output logic              adv,
    input  logic [OFF_W-1:0]  cur_off,
    input  logic              tbl_present,
    input  logic [OFF_W-1:0]  tbl_len,
    input  logic              tbl_writable,
    input  logic [7:0]        tbl_rbyte,
    output logic              tbl_we,
    output logic [7:0]        tbl_wbyte,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_rsp,
    input  logic              mem_err,
    input  logic [7:0]        mem_rdata
);
    localparam int CNT_W = $clog2(DESC_BYTES);

    eng_state_e        state_q;
    op_e               op_q;
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  bcnt_q;
    logic [KEY_W-1:0]  key_q;
    logic [FLG_W-1:0]  flg_q;
    logic [DLEN_W-1:0] len_sh;
    logic [63:0]       tgt_sh;
    logic [ADDR_W-1:0] taddr_q;
    logic [DLEN_W-1:0] remain_q;
    logic              err_q;

    logic              in_range;
    logic              done;
    logic              wr_ok;
    logic              need_mem;
    logic              wr_fail;
    logic              skip_step;
    logic              mem_step;
    logic [ADDR_W-1:0] base_idx;

    // data-phase decisions for the current byte
    always_comb begin
        in_range  = tbl_present && (cur_off < tbl_len);
        done      = (remain_q == '0) || err_q;
        wr_ok     = in_range && tbl_writable;
        need_mem  = (state_q == ST_MOVE) && !done && ((op_q == OP_RD) || (op_q == OP_WR && wr_ok));
        wr_fail   = (state_q == ST_MOVE) && !done && (op_q == OP_WR) && !wr_ok;
        skip_step = (state_q == ST_MOVE) && !done && (op_q == OP_SKIP);
        mem_step  = need_mem && mem_rsp && !mem_err;
        base_idx  = base_q + ADDR_W'(bcnt_q);
    end

    // cursor and table strobes
    always_comb begin
        adv       = (mem_step || skip_step) && in_range;
        tbl_we    = mem_step && (op_q == OP_WR);
        tbl_wbyte = mem_rdata;
        sel_pulse = (state_q == ST_DECODE) && flg_q[CTL_SEL];
        sel_key   = key_q;
        busy      = (state_q != ST_IDLE);
    end

    // memory master request per state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = base_idx;
        mem_wdata = 8'h00;
        case (state_q)
            ST_FETCH: mem_req = 1'b1;
            ST_MOVE: begin
                mem_req   = need_mem;
                mem_we    = (op_q == OP_RD);
                mem_addr  = taddr_q;
                mem_wdata = in_range ? tbl_rbyte : 8'h00;
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = (bcnt_q == CNT_W'(STAT_BYTES - 1)) ? {7'b0, err_q} : 8'h00;
            end
            default: ;
        endcase
    end

    // sequencing of fetch, decode, data phase and status write-back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            op_q     <= OP_NONE;
            base_q   <= '0;
            bcnt_q   <= '0;
            key_q    <= '0;
            flg_q    <= '0;
            len_sh   <= '0;
            tgt_sh   <= '0;
            taddr_q  <= '0;
            remain_q <= '0;
            err_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (go) begin
                        base_q  <= base_in;
                        bcnt_q  <= '0;
                        err_q   <= 1'b0;
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_rsp) begin
                        if (mem_err) begin
                            err_q   <= 1'b1;
                            bcnt_q  <= '0;
                            state_q <= ST_WBACK;
                        end else begin
                            case (bcnt_q)
                                4'd0:    key_q[15:8] <= mem_rdata;
                                4'd1:    key_q[7:0]  <= mem_rdata;
                                4'd2:    ;
                                4'd3:    flg_q       <= mem_rdata[FLG_W-1:0];
                                4'd4, 4'd5, 4'd6, 4'd7:
                                         len_sh      <= {len_sh[DLEN_W-9:0], mem_rdata};
                                default: tgt_sh      <= {tgt_sh[55:0], mem_rdata};
                            endcase
                            if (bcnt_q == CNT_W'(DESC_BYTES - 1)) state_q <= ST_DECODE;
                            else                                  bcnt_q  <= bcnt_q + 1'b1;
                        end
                    end
                end
                ST_DECODE: begin
                    err_q    <= flg_q[CTL_ERR];
                    taddr_q  <= tgt_sh[ADDR_W-1:0];
                    remain_q <= len_sh;
                    if (flg_q[CTL_RD])        op_q <= OP_RD;
                    else if (flg_q[CTL_WR])   op_q <= OP_WR;
                    else if (flg_q[CTL_SKIP]) op_q <= OP_SKIP;
                    else begin
                        op_q     <= OP_NONE;
                        remain_q <= '0;
                    end
                    state_q <= ST_MOVE;
                end
                ST_MOVE: begin
                    if (done) begin
                        bcnt_q  <= '0;
                        state_q <= ST_WBACK;
                    end else if (wr_fail) begin
                        err_q <= 1'b1;
                    end else if (need_mem && mem_rsp) begin
                        if (mem_err) err_q <= 1'b1;
                        else begin
                            taddr_q  <= taddr_q + 1'b1;
                            remain_q <= remain_q - 1'b1;
                        end
                    end else if (skip_step) begin
                        taddr_q  <= taddr_q + 1'b1;
                        remain_q <= remain_q - 1'b1;
                    end
                end
                ST_WBACK: begin
                    if (mem_rsp) begin
                        if (bcnt_q == CNT_W'(STAT_BYTES - 1)) state_q <= ST_IDLE;
                        else                                  bcnt_q  <= bcnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfgdma_top.sv
// Top of the configuration DMA engine: register window, shared cursor and engine.
// Assumes the item table is external and indexed by cur_key / cur_off.
module cfgdma_top
    import cfgdma_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int OFF_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_we,
    input  logic [2:0]        win_off,
    input  logic [3:0]        win_size,
    input  logic [63:0]       win_wdata,
    output logic [63:0]       win_rdata,
    output logic              busy,
    input  logic              host_sel,
    input  logic [KEY_W-1:0]  host_key,
    output logic [KEY_W-1:0]  cur_key,
    output logic [OFF_W-1:0]  cur_off,
    input  logic              tbl_present,
    input  logic [OFF_W-1:0]  tbl_len,
    input  logic              tbl_writable,
    input  logic [7:0]        tbl_rbyte,
    output logic              tbl_we,
    output logic [7:0]        tbl_wbyte,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_rsp,
    input  logic              mem_err,
    input  logic [7:0]        mem_rdata
);
    logic              go;
    logic [ADDR_W-1:0] desc_addr;
    logic              eng_sel;
    logic [KEY_W-1:0]  eng_key;
    logic              adv;
    logic              host_ok;

    // host selection only when no transfer is running
    assign host_ok = host_sel && !busy;

    cfgdma_regwin #(.ADDR_W(ADDR_W)) u_win (
        .clk(clk), .rst_n(rst_n),
        .win_we(win_we), .win_off(win_off), .win_size(win_size),
        .win_wdata(win_wdata), .win_rdata(win_rdata),
        .busy(busy), .desc_addr(desc_addr), .go(go)
    );

    cfgdma_cursor #(.OFF_W(OFF_W)) u_cur (
        .clk(clk), .rst_n(rst_n),
        .host_sel(host_ok), .host_key(host_key),
        .eng_sel(eng_sel), .eng_key(eng_key), .adv(adv),
        .cur_key(cur_key), .cur_off(cur_off)
    );

    cfgdma_engine #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .go(go), .base_in(desc_addr), .busy(busy),
        .sel_pulse(eng_sel), .sel_key(eng_key), .adv(adv),
        .cur_off(cur_off), .tbl_present(tbl_present), .tbl_len(tbl_len),
        .tbl_writable(tbl_writable), .tbl_rbyte(tbl_rbyte),
        .tbl_we(tbl_we), .tbl_wbyte(tbl_wbyte),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rsp(mem_rsp), .mem_err(mem_err),
        .mem_rdata(mem_rdata)
    );
endmodule

// File: rtl/cfgdma_chk.sv
// Protocol and behaviour checker for cfgdma_top, attached by bind.
module cfgdma_chk
    import cfgdma_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int OFF_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              win_we,
    input logic [2:0]        win_off,
    input logic [3:0]        win_size,
    input logic [63:0]       win_wdata,
    input logic [63:0]       win_rdata,
    input logic              busy,
    input logic              host_sel,
    input logic [KEY_W-1:0]  host_key,
    input logic [KEY_W-1:0]  cur_key,
    input logic [OFF_W-1:0]  cur_off,
    input logic              tbl_present,
    input logic [OFF_W-1:0]  tbl_len,
    input logic              tbl_writable,
    input logic [7:0]        tbl_rbyte,
    input logic              tbl_we,
    input logic [7:0]        tbl_wbyte,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              mem_rsp,
    input logic              mem_err,
    input logic [7:0]        mem_rdata
);
    AST_TRIGGER_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && win_we && ((win_off == 3'd4 && win_size == 4'd4) || (win_off == 3'd0 && win_size == 4'd8))) |=> busy); // R3

    AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req); // R11

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rsp) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R13

    AST_TBL_WRITE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> (tbl_present && tbl_writable && busy)); // R7

    AST_SIG_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (win_off == 3'd0 && win_size == 4'd8) |-> (win_rdata == 64'h51454d5520434647)); // R2

    AST_HOST_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && !busy) |=> (cur_off == '0 && cur_key == $past(host_key))); // R12

    AST_HOST_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && busy && !tbl_we) |=> (cur_key == $past(cur_key))); // R12
endmodule

bind cfgdma_top cfgdma_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/sim_cfgdma_top.sv
module sim_cfgdma_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        win_we = 1'b0;
    logic [2:0]  win_off = '0;
    logic [3:0]  win_size = '0;
    logic [63:0] win_wdata = '0;
    logic [63:0] win_rdata;
    logic        busy;
    logic        host_sel = 1'b0;
    logic [15:0] host_key = '0;
    logic [15:0] cur_key;
    logic [31:0] cur_off;
    logic        tbl_present;
    logic [31:0] tbl_len;
    logic        tbl_writable;
    logic [7:0]  tbl_rbyte;
    logic        tbl_we;
    logic [7:0]  tbl_wbyte;
    logic        mem_req;
    logic        mem_we;
    logic [63:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_rsp = 1'b0;
    logic        mem_err = 1'b0;
    logic [7:0]  mem_rdata = '0;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    int acc_cnt = 0;

    logic [7:0] mem [0:255];
    logic [7:0] item [0:3][0:15];
    logic [7:0] shadow [0:3][0:15];

    always #5 clk = ~clk;

    cfgdma_top u0 (.*);

    function automatic int klen(int k);
        return 4 + 3 * k;
    endfunction

    function automatic logic [7:0] pat(int k, int o);
        return 8'((k * 37 + o * 5 + 1) & 255);
    endfunction

    // item table model: keys 0..3 present, keys 1 and 3 writable
    assign tbl_present  = (cur_key < 16'd4);
    assign tbl_len      = (cur_key < 16'd4) ? 32'(klen(int'(cur_key))) : 32'd0;
    assign tbl_writable = (cur_key == 16'd1) || (cur_key == 16'd3);
    assign tbl_rbyte    = (cur_key < 16'd4 && cur_off < 32'd16) ? item[cur_key[1:0]][cur_off[3:0]] : 8'h00;

    always @(posedge clk) if (tbl_we) item[cur_key[1:0]][cur_off[3:0]] <= tbl_wbyte;

    // memory model: one-cycle response, faults above address 0xFF
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rsp <= 1'b0;
            mem_err <= 1'b0;
        end else if (mem_req && !mem_rsp) begin
            mem_rsp <= 1'b1;
            acc_cnt <= acc_cnt + 1;
            if (mem_addr[63:8] != '0) mem_err <= 1'b1;
            else begin
                mem_err <= 1'b0;
                if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[7:0]];
            end
        end else begin
            mem_rsp <= 1'b0;
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_bad++;
                $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
                summary();
            end
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic fill(int start, int n, logic [7:0] v);
        for (int i = 0; i < n; i++) if (start + i < 256) mem[start + i] = v;
    endtask

    task automatic put_desc(int base, logic [31:0] ctl, logic [31:0] len, logic [63:0] tgt);
        logic [127:0] d;
        d = {ctl, len, tgt};
        for (int i = 0; i < 16; i++) if (base + i < 256) mem[base + i] = d[127 - 8*i -: 8];
    endtask

    task automatic win_write(logic [2:0] off, logic [3:0] size, logic [63:0] data);
        @(negedge clk);
        win_we = 1'b1; win_off = off; win_size = size; win_wdata = data;
        @(negedge clk);
        win_we = 1'b0;
    endtask

    task automatic kick(int base, bit use8);
        if (use8) win_write(3'd0, 4'd8, 64'(base));
        else begin
            win_write(3'd0, 4'd4, 64'd0);
            win_write(3'd4, 4'd4, 64'(base));
        end
    endtask

    task automatic wait_idle();
        int t;
        t = 0;
        while (busy && t < 5000) begin @(negedge clk); t++; end
        if (busy) chk("R11 busy timeout", 64'(busy), 64'd0);
    endtask

    task automatic dma(int base, logic [31:0] ctl, logic [31:0] len, logic [63:0] tgt, bit use8);
        put_desc(base, ctl, len, tgt);
        kick(base, use8);
        wait_idle();
    endtask

    function automatic logic [31:0] status_at(int base);
        return {mem[base], mem[base+1], mem[base+2], mem[base+3]};
    endfunction

    function automatic logic [31:0] ctlw(int key, int bits);
        return {16'(key), 16'(bits)};
    endfunction

    initial begin
        logic [63:0] sig;
        logic [63:0] v;
        int a0;
        int o;
        sig = 64'h51454d5520434647;
        for (int k = 0; k < 4; k++)
            for (int o2 = 0; o2 < 16; o2++) begin
                item[k][o2]   = pat(k, o2);
                shadow[k][o2] = pat(k, o2);
            end
        fill(0, 256, 8'h00);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 busy", 64'(busy), 0);
        chk("R1 mem_req", 64'(mem_req), 0);
        chk("R1 cur_key", 64'(cur_key), 0);
        chk("R1 cur_off", 64'(cur_off), 0);

        // R2: every offset/size combination of the signature window
        for (int off = 0; off < 8; off++)
            for (int sz = 1; sz <= 8; sz++) begin
                @(negedge clk);
                win_off = 3'(off); win_size = 4'(sz);
                #1;
                v = 0;
                if (off + sz <= 8)
                    for (int j = 0; j < sz; j++) v = (v << 8) | 64'(sig[63 - 8*(off+j) -: 8]);
                chk($sformatf("R2 sig off=%0d size=%0d", off, sz), win_rdata, v);
            end

        // R3: a high-half write alone starts nothing
        put_desc(0, ctlw(0, 'h0A), 4, 64'h40);
        win_write(3'd0, 4'd4, 64'd0);
        repeat (10) @(negedge clk);
        chk("R3 high-half write no start", 64'(busy), 0);
        win_write(3'd4, 4'd4, 64'd0);
        chk("R3 low-half write starts", 64'(busy), 1);
        wait_idle();

        // R4 R6 R11: read sweep over keys and lengths, both trigger shapes
        for (int k = 0; k < 6; k++)
            for (int n = 0; n < 14; n++) begin
                fill(8'h40, 16, 8'hAA);
                a0 = acc_cnt;
                dma(0, ctlw(k, 'h0A), 32'(n), 64'h40, n[0]);
                for (int i = 0; i < 16; i++) begin
                    if (i >= n)                    v = 64'hAA;
                    else if (k < 4 && i < klen(k)) v = 64'(shadow[k][i]);
                    else                           v = 64'h00;
                    chk($sformatf("R6 R4 read k=%0d n=%0d byte %0d", k, n, i), 64'(mem[8'h40 + i]), v);
                end
                chk($sformatf("R6 offset k=%0d n=%0d", k, n), 64'(cur_off),
                    64'((k < 4) ? ((n < klen(k)) ? n : klen(k)) : 0));
                chk($sformatf("R11 status k=%0d n=%0d", k, n), 64'(status_at(0)), 0);
                chk($sformatf("R13 accesses k=%0d n=%0d", k, n), 64'(acc_cnt - a0), 64'(20 + n));
            end

        // R8 R13: skip then read without select
        for (int s = 0; s < 15; s++) begin
            a0 = acc_cnt;
            dma(0, ctlw(3, 'h0C), 32'(s), 64'h40, 1'b1);
            chk($sformatf("R13 R8 skip no data access s=%0d", s), 64'(acc_cnt - a0), 20);
            o = (s < 13) ? s : 13;
            chk($sformatf("R8 skip offset s=%0d", s), 64'(cur_off), 64'(o));
            fill(8'h40, 16, 8'hAA);
            dma(0, ctlw(0, 'h02), 16, 64'h40, 1'b0);
            for (int i = 0; i < 16; i++)
                chk($sformatf("R8 after skip s=%0d byte %0d", s, i), 64'(mem[8'h40 + i]),
                    64'((o + i < 13) ? shadow[3][o + i] : 8'h00));
        end

        // R7: full write into writable key 1
        for (int i = 0; i < 7; i++) mem[8'h80 + i] = 8'hC0 + 8'(i);
        dma(0, ctlw(1, 'h18), 7, 64'h80, 1'b1);
        chk("R7 write status ok", 64'(status_at(0)), 0);
        chk("R7 write offset", 64'(cur_off), 7);
        for (int i = 0; i < 7; i++) shadow[1][i] = 8'hC0 + 8'(i);
        fill(8'h40, 16, 8'hAA);
        dma(0, ctlw(1, 'h0A), 7, 64'h40, 1'b0);
        for (int i = 0; i < 7; i++) chk($sformatf("R7 readback byte %0d", i), 64'(mem[8'h40 + i]), 64'(shadow[1][i]));

        // R7: write running past the end of key 3
        for (int i = 0; i < 15; i++) mem[8'h80 + i] = 8'h70 + 8'(i);
        dma(0, ctlw(3, 'h18), 15, 64'h80, 1'b0);
        chk("R7 write past end status", 64'(status_at(0)), 1);
        chk("R7 write past end offset", 64'(cur_off), 13);
        for (int i = 0; i < 13; i++) shadow[3][i] = 8'h70 + 8'(i);

        // R7: write to read-only and absent keys
        dma(0, ctlw(2, 'h18), 3, 64'h80, 1'b1);
        chk("R7 read-only status", 64'(status_at(0)), 1);
        chk("R7 read-only offset", 64'(cur_off), 0);
        dma(0, ctlw(7, 'h18), 3, 64'h80, 1'b1);
        chk("R7 absent status", 64'(status_at(0)), 1);
        fill(8'h40, 16, 8'hAA);
        dma(0, ctlw(2, 'h0A), 3, 64'h40, 1'b0);
        for (int i = 0; i < 3; i++) chk($sformatf("R7 read-only unchanged %0d", i), 64'(mem[8'h40 + i]), 64'(shadow[2][i]));

        // R9: read beats write and skip
        fill(8'h40, 16, 8'hAA);
        dma(0, ctlw(2, 'h1E), 4, 64'h40, 1'b1);
        chk("R9 read priority status", 64'(status_at(0)), 0);
        for (int i = 0; i < 4; i++) chk($sformatf("R9 read priority byte %0d", i), 64'(mem[8'h40 + i]), 64'(shadow[2][i]));
        // R9: write beats skip
        mem[8'h80] = 8'h55; mem[8'h81] = 8'h66;
        dma(0, ctlw(1, 'h1C), 2, 64'h80, 1'b1);
        shadow[1][0] = 8'h55; shadow[1][1] = 8'h66;
        fill(8'h40, 16, 8'hAA);
        dma(0, ctlw(1, 'h0A), 2, 64'h40, 1'b0);
        chk("R9 write over skip byte 0", 64'(mem[8'h40]), 64'h55);
        chk("R9 write over skip byte 1", 64'(mem[8'h41]), 64'h66);

        // R5: select with no operation, and error bit preset
        fill(8'h40, 16, 8'hAA);
        a0 = acc_cnt;
        dma(0, ctlw(3, 'h08), 9, 64'h40, 1'b1);
        chk("R5 no-op key", 64'(cur_key), 3);
        chk("R5 no-op offset", 64'(cur_off), 0);
        chk("R5 no-op status", 64'(status_at(0)), 0);
        chk("R5 no-op accesses", 64'(acc_cnt - a0), 20);
        dma(0, ctlw(2, 'h0B), 4, 64'h40, 1'b0);
        chk("R5 preset error status", 64'(status_at(0)), 1);
        chk("R5 preset error key", 64'(cur_key), 2);
        chk("R5 preset error no data", 64'(mem[8'h40]), 64'hAA);

        // R10: data fault crossing 0x100
        dma(0, ctlw(3, 'h0A), 10, 64'hF8, 1'b1);
        chk("R10 data fault status", 64'(status_at(0)), 1);
        chk("R10 data fault offset", 64'(cur_off), 8);
        for (int i = 0; i < 8; i++) chk($sformatf("R10 bytes before fault %0d", i), 64'(mem[8'hF8 + i]), 64'(shadow[3][i]));
        // R10: descriptor fetch fault
        dma(8'hF8, ctlw(1, 'h0A), 4, 64'h40, 1'b0);
        chk("R10 fetch fault status", 64'(status_at(8'hF8)), 1);
        chk("R10 fetch fault key unchanged", 64'(cur_key), 3);

        // R12: host select in the trigger cycle, then select and trigger while busy
        put_desc(0, ctlw(0, 'h02), 5, 64'h40);
        put_desc(8'h20, ctlw(1, 'h0A), 4, 64'hC0);
        fill(8'h40, 16, 8'hAA);
        fill(8'hC0, 16, 8'hAA);
        win_write(3'd0, 4'd4, 64'd0);
        @(negedge clk);
        win_we = 1'b1; win_off = 3'd4; win_size = 4'd4; win_wdata = 64'd0;
        host_sel = 1'b1; host_key = 16'd2;
        @(negedge clk);
        win_we = 1'b0; host_sel = 1'b0;
        chk("R11 busy after trigger", 64'(busy), 1);
        repeat (4) @(negedge clk);
        win_we = 1'b1; win_off = 3'd0; win_size = 4'd8; win_wdata = 64'h20;
        host_sel = 1'b1; host_key = 16'd3;
        @(negedge clk);
        win_we = 1'b0; host_sel = 1'b0;
        wait_idle();
        repeat (100) @(negedge clk);
        chk("R12 second trigger ignored busy", 64'(busy), 0);
        chk("R12 key from same-cycle select", 64'(cur_key), 2);
        chk("R12 offset after transfer", 64'(cur_off), 5);
        for (int i = 0; i < 5; i++) chk($sformatf("R12 data from host key byte %0d", i), 64'(mem[8'h40 + i]), 64'(shadow[2][i]));
        chk("R12 ignored target untouched", 64'(mem[8'hC0]), 64'hAA);
        chk("R11 idle no request", 64'(mem_req), 0);

        summary();
    end
endmodule